// File: doc/BRIEF.md
# Data-Side IO Decoder with Keyed Program-Memory Writer

This block sits on the data-memory port of a small processor. Every access carries a 17-bit byte address. When bit 16 is clear, the access goes straight to the data RAM port. The RAM address is aligned to the access size. When bit 16 is set, the access lands in a small IO window. That window holds:

- a console byte port, with output on writes and input on reads through a valid/ready handshake;
- a free-running timer that reads back elapsed clock cycles divided by a prescale factor (100 by default);
- a debug strobe;
- an exit strobe that carries a halt code supplied from outside.

The IO window also holds a guarded path into the separate program memory. Software first stores a 32-bit key to an unlock register and then loads a target address. Each later store to the data register becomes a program-memory write at that address, and the address moves up by four after each one. While the path is locked, stores to the data register are dropped. A read of an IO address that is not decoded flags an illegal access. A write to an IO address that is not decoded is only flagged and has no other effect.

All decode and forwarding is combinational in the cycle of the request. The unlock flag, the program-memory address and the timer are the only state, and each of them changes on the clock edge that ends a request.

Top module: `dmem_io_bridge`

## Requirements
- R1: With `reqAddr[16]` clear, a valid access drives `ramEn`, `ramWe` equals `reqWrite`, `ramWdata` and `ramSize` follow the request, and a read returns `ramRdata` on `rdata`; no IO strobe fires.
- R2: Size code 0 is byte, 1 is 16-bit, 2 is 32-bit. The RAM address and the program-memory address clear bit 0 for size 1 and bits 1:0 for size 2; size 0 leaves them untouched.
- R3: Writing 0x1337F7D1 to IO address 0x1FC80 sets the unlock flag. Writing any other value there clears it. Reset leaves it clear.
- R4: A write to 0x1FC84 loads the 32-bit program-memory address with the write data.
- R5: A write to 0x1FC88 while unlocked raises `pmWe` with `pmAddr` and `pmWdata` for that access, and the stored address then grows by 4. While locked, `pmWe` stays low and `pmAddr` does not change.
- R6: A write to 0x10000 raises `conOutValid` for one cycle with `conOutByte` equal to the low 8 bits of the data.
- R7: A read of 0x10000 raises `conInReady`. It returns `conInByte` zero-extended when `conInValid` is high, and 0xFFFFFFFF otherwise.
- R8: A read of 0x1FFF4 returns the number of clock edges since reset was released, divided by 100 and rounded down.
- R9: A write to 0x1FFFC raises `exitValid` with `exitData` equal to `exitCode`. A write to 0x1FFF8 raises `dbgValid` with `dbgData` equal to the write data.
- R10: A read of any IO address other than 0x10000 and 0x1FFF4 raises `illegalRead`. A write to an undecoded IO address raises `unknownWrite` only. The `rdata` bus reads 0 whenever no decoded read is in progress.
- R11: During and just after reset, with no request, every strobe is low, `rdata` is 0, `pmAddr` is 0 and the path is locked.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| reqValid | input | 1 | Access request this cycle |
| reqWrite | input | 1 | 1 for a store, 0 for a load |
| reqSize | input | 2 | 0 byte, 1 half-word, 2 word |
| reqAddr | input | 17 | Byte address; bit 16 selects the IO window |
| reqWdata | input | 32 | Store data |
| rdata | output | 32 | Load result |
| illegalRead | output | 1 | Load from an undecoded IO address |
| unknownWrite | output | 1 | Store to an undecoded IO address |
| ramEn | output | 1 | Data RAM access |
| ramWe | output | 1 | Data RAM write |
| ramAddr | output | 16 | Aligned RAM byte address |
| ramSize | output | 2 | RAM access size |
| ramWdata | output | 32 | RAM write data |
| ramRdata | input | 32 | RAM read data |
| pmWe | output | 1 | Program-memory write strobe |
| pmAddr | output | 32 | Aligned program-memory address |
| pmSize | output | 2 | Program-memory write size |
| pmWdata | output | 32 | Program-memory write data |
| conOutValid | output | 1 | Console output byte strobe |
| conOutByte | output | 8 | Console output byte |
| conInValid | input | 1 | Console input byte available |
| conInByte | input | 8 | Console input byte |
| conInReady | output | 1 | Console input byte taken |
| dbgValid | output | 1 | Debug strobe |
| dbgData | output | 32 | Debug value |
| exitValid | output | 1 | Exit strobe |
| exitCode | input | 32 | Halt code supplied by the core |
| exitData | output | 32 | Halt code sent with the exit strobe |

## Verification
The hardest state to reach is a locked path that holds a non-zero, partly advanced address. From there, a rejected data store must leave `pmAddr` where it was. The stimulus reaches it in steps: it unlocks with the key, loads an address, and issues several data stores so the address advances. It then relocks with a wrong key and issues more data stores, with sizes that change how the visible address is aligned. A reset in the middle of the run brings the timer quotient, the lock and the address back to their reset values. A wait of more than 200 idle cycles drives the timer past two prescale boundaries before it is read.

// File: rtl/iobr_pkg.sv
package iobr_pkg;
  localparam int ADDR_W = 17;
  localparam int DATA_W = 32;

  localparam logic [ADDR_W-1:0] IO_CONSOLE = 17'h10000;
  localparam logic [ADDR_W-1:0] IO_KEY     = 17'h1FC80;
  localparam logic [ADDR_W-1:0] IO_PMADDR  = 17'h1FC84;
  localparam logic [ADDR_W-1:0] IO_PMDATA  = 17'h1FC88;
  localparam logic [ADDR_W-1:0] IO_TIMER   = 17'h1FFF4;
  localparam logic [ADDR_W-1:0] IO_DEBUG   = 17'h1FFF8;
  localparam logic [ADDR_W-1:0] IO_EXIT    = 17'h1FFFC;

  typedef struct packed {
    logic ramRd;
    logic ramWr;
    logic conWr;
    logic conRd;
    logic timerRd;
    logic dbgWr;
    logic exitWr;
    logic keyWr;
    logic pmAddrWr;
    logic pmDataWr;
    logic badRd;
    logic badWr;
  } ioStrobes_t;

  function automatic logic [DATA_W-1:0] alignBySize(input logic [DATA_W-1:0] a,
                                                    input logic [1:0] sz);
    logic [DATA_W-1:0] r;
    r = a;
    if (sz == 2'd1) r[0] = 1'b0;
    else if (sz == 2'd2) r[1:0] = 2'b00;
    return r;
  endfunction
endpackage

// File: rtl/iobr_ctrl.sv
module iobr_ctrl
  import iobr_pkg::*;
(
  input  logic              reqValid,
  input  logic              reqWrite,
  input  logic [ADDR_W-1:0] reqAddr,
  output ioStrobes_t        stb
);
  logic isIo;
  assign isIo = reqAddr[ADDR_W-1];

  always_comb begin
    stb = '0;
    if (reqValid) begin
      if (!isIo) begin
        stb.ramRd = !reqWrite;
        stb.ramWr = reqWrite;
      end else if (reqWrite) begin
        case (reqAddr)
          IO_CONSOLE: stb.conWr    = 1'b1;
          IO_KEY:     stb.keyWr    = 1'b1;
          IO_PMADDR:  stb.pmAddrWr = 1'b1;
          IO_PMDATA:  stb.pmDataWr = 1'b1;
          IO_DEBUG:   stb.dbgWr    = 1'b1;
          IO_EXIT:    stb.exitWr   = 1'b1;
          default:    stb.badWr    = 1'b1;
        endcase
      end else begin
        case (reqAddr)
          IO_CONSOLE: stb.conRd   = 1'b1;
          IO_TIMER:   stb.timerRd = 1'b1;
          default:    stb.badRd   = 1'b1;
        endcase
      end
    end
  end

  // R10
  always_comb begin
    strobe_onehot_chk: assert ($onehot0(stb) && (reqValid || stb == '0));
  end
endmodule

// File: rtl/iobr_dp.sv
module iobr_dp
  import iobr_pkg::*;
#(
  parameter int              TICK_DIV   = 100,
  parameter logic [DATA_W-1:0] UNLOCK_KEY = 32'h1337F7D1
) (
  input  logic              clk,
  input  logic              rst,
  input  ioStrobes_t        stb,
  input  logic [1:0]        reqSize,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [DATA_W-1:0] reqWdata,
  input  logic [DATA_W-1:0] exitCode,
  input  logic [DATA_W-1:0] ramRdata,
  input  logic              conInValid,
  input  logic [7:0]        conInByte,
  output logic [DATA_W-1:0] rdata,
  output logic              ramEn,
  output logic              ramWe,
  output logic [ADDR_W-2:0] ramAddr,
  output logic              pmWe,
  output logic [DATA_W-1:0] pmAddr,
  output logic              conOutValid,
  output logic [7:0]        conOutByte,
  output logic              conInReady,
  output logic              dbgValid,
  output logic [DATA_W-1:0] dbgData,
  output logic              exitValid,
  output logic [DATA_W-1:0] exitData,
  output logic              illegalRead,
  output logic              unknownWrite
);
  localparam int PRE_W = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;
  localparam logic [PRE_W-1:0] PRE_LAST = PRE_W'(TICK_DIV - 1);
  localparam int RAM_W = ADDR_W - 1;

  logic              unlocked;
  logic [DATA_W-1:0] pmAddrQ;
  logic [PRE_W-1:0]  prescale;
  logic [DATA_W-1:0] tickCount;
  logic [DATA_W-1:0] ramWide;

  // Keyed program-memory write path
  always_ff @(posedge clk) begin
    if (rst) begin
      unlocked <= 1'b0;
      pmAddrQ  <= '0;
    end else begin
      if (stb.keyWr) unlocked <= (reqWdata == UNLOCK_KEY);
      if (stb.pmAddrWr) pmAddrQ <= reqWdata;
      else if (stb.pmDataWr && unlocked) pmAddrQ <= pmAddrQ + DATA_W'(4);
    end
  end

  // Prescaled cycle timer
  always_ff @(posedge clk) begin
    if (rst) begin
      prescale  <= '0;
      tickCount <= '0;
    end else if (prescale == PRE_LAST) begin
      prescale  <= '0;
      tickCount <= tickCount + 1'b1;
    end else begin
      prescale <= prescale + 1'b1;
    end
  end

  assign ramWide = alignBySize({{(DATA_W-RAM_W){1'b0}}, reqAddr[RAM_W-1:0]}, reqSize);
  assign ramAddr = ramWide[RAM_W-1:0];
  assign ramEn   = stb.ramRd | stb.ramWr;
  assign ramWe   = stb.ramWr;

  assign pmWe   = stb.pmDataWr & unlocked;
  assign pmAddr = alignBySize(pmAddrQ, reqSize);

  assign conOutValid = stb.conWr;
  assign conOutByte  = reqWdata[7:0];
  assign conInReady  = stb.conRd;
  assign dbgValid    = stb.dbgWr;
  assign dbgData     = reqWdata;
  assign exitValid   = stb.exitWr;
  assign exitData    = exitCode;
  assign illegalRead  = stb.badRd;
  assign unknownWrite = stb.badWr;

  always_comb begin
    rdata = '0;
    if (stb.ramRd) rdata = ramRdata;
    else if (stb.conRd) rdata = conInValid ? {{(DATA_W-8){1'b0}}, conInByte} : '1;
    else if (stb.timerRd) rdata = tickCount;
  end

  // R5
  pm_step_chk: assert property (@(posedge clk) disable iff (rst)
    pmWe |=> (pmAddrQ == $past(pmAddrQ) + DATA_W'(4)));
  // R5
  pm_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!unlocked && !stb.pmAddrWr) |=> $stable(pmAddrQ));
  // R3
  unlock_set_chk: assert property (@(posedge clk) disable iff (rst)
    (stb.keyWr && reqWdata == UNLOCK_KEY) |=> unlocked);
  // R8
  tick_step_chk: assert property (@(posedge clk) disable iff (rst)
    (tickCount != $past(tickCount)) |-> ($past(prescale) == PRE_LAST));
  // R8
  tick_bound_chk: assert property (@(posedge clk) disable iff (rst)
    prescale <= PRE_LAST);
  // R2
  always_comb begin
    ram_align_chk: assert (!(ramEn && reqSize == 2'd2) || ramAddr[1:0] == 2'b00);
  end
endmodule

// File: rtl/dmem_io_bridge.sv
module dmem_io_bridge
  import iobr_pkg::*;
#(
  parameter int          TICK_DIV   = 100,
  parameter logic [31:0] UNLOCK_KEY = 32'h1337F7D1
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        reqValid,
  input  logic        reqWrite,
  input  logic [1:0]  reqSize,
  input  logic [16:0] reqAddr,
  input  logic [31:0] reqWdata,
  output logic [31:0] rdata,
  output logic        illegalRead,
  output logic        unknownWrite,
  output logic        ramEn,
  output logic        ramWe,
  output logic [15:0] ramAddr,
  output logic [1:0]  ramSize,
  output logic [31:0] ramWdata,
  input  logic [31:0] ramRdata,
  output logic        pmWe,
  output logic [31:0] pmAddr,
  output logic [1:0]  pmSize,
  output logic [31:0] pmWdata,
  output logic        conOutValid,
  output logic [7:0]  conOutByte,
  input  logic        conInValid,
  input  logic [7:0]  conInByte,
  output logic        conInReady,
  output logic        dbgValid,
  output logic [31:0] dbgData,
  output logic        exitValid,
  input  logic [31:0] exitCode,
  output logic [31:0] exitData
);
  ioStrobes_t stb;

  assign ramSize  = reqSize;
  assign ramWdata = reqWdata;
  assign pmSize   = reqSize;
  assign pmWdata  = reqWdata;

  iobr_ctrl u_ctrl (
    .reqValid (reqValid),
    .reqWrite (reqWrite),
    .reqAddr  (reqAddr),
    .stb      (stb)
  );

  iobr_dp #(
    .TICK_DIV   (TICK_DIV),
    .UNLOCK_KEY (UNLOCK_KEY)
  ) u_dp (
    .clk          (clk),
    .rst          (rst),
    .stb          (stb),
    .reqSize      (reqSize),
    .reqAddr      (reqAddr),
    .reqWdata     (reqWdata),
    .exitCode     (exitCode),
    .ramRdata     (ramRdata),
    .conInValid   (conInValid),
    .conInByte    (conInByte),
    .rdata        (rdata),
    .ramEn        (ramEn),
    .ramWe        (ramWe),
    .ramAddr      (ramAddr),
    .pmWe         (pmWe),
    .pmAddr       (pmAddr),
    .conOutValid  (conOutValid),
    .conOutByte   (conOutByte),
    .conInReady   (conInReady),
    .dbgValid     (dbgValid),
    .dbgData      (dbgData),
    .exitValid    (exitValid),
    .exitData     (exitData),
    .illegalRead  (illegalRead),
    .unknownWrite (unknownWrite)
  );
endmodule

// File: tb/sim_dmem_io_bridge.sv
`timescale 1ns/1ps
module sim_dmem_io_bridge;
  localparam int          PERIOD = 20;
  localparam logic [31:0] KEY    = 32'h1337F7D1;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        reqValid = 1'b0, reqWrite = 1'b0;
  logic [1:0]  reqSize = 2'd2;
  logic [16:0] reqAddr = '0;
  logic [31:0] reqWdata = '0, ramRdata = '0, exitCode = '0;
  logic        conInValid = 1'b0;
  logic [7:0]  conInByte = '0;
  logic [31:0] rdata, ramWdata, pmAddr, pmWdata, dbgData, exitData;
  logic [15:0] ramAddr;
  logic [1:0]  ramSize, pmSize;
  logic [7:0]  conOutByte;
  logic        illegalRead, unknownWrite, ramEn, ramWe, pmWe;
  logic        conOutValid, conInReady, dbgValid, exitValid;

  int nChecks = 0, nFail = 0;
  bit finished = 0;

  // reference state
  int unsigned mCycles = 0;
  bit          mUnlocked = 0;
  logic [31:0] mPmAddr = '0;

  always #(PERIOD/2) clk = ~clk;

  dmem_io_bridge u0 (.*);

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic [31:0] algn(input logic [31:0] a, input logic [1:0] s);
    if (s == 2'd1) return a & ~32'd1;
    if (s == 2'd2) return a & ~32'd3;
    return a;
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      mCycles = 0; mUnlocked = 0; mPmAddr = '0;
    end else begin
      mCycles++;
      if (reqValid && reqWrite) begin
        if (reqAddr == 17'h1FC80) mUnlocked = (reqWdata == KEY);
        else if (reqAddr == 17'h1FC84) mPmAddr = reqWdata;
        else if (reqAddr == 17'h1FC88 && mUnlocked) mPmAddr = mPmAddr + 4;
      end
    end
  end

  // compare against the model every cycle, away from the active edge
  always @(negedge clk) begin
    bit io, rd, wr, knownW;
    logic [31:0] expR;
    io = reqAddr[16];
    rd = reqValid && !reqWrite;
    wr = reqValid && reqWrite;
    knownW = reqAddr inside {17'h10000, 17'h1FC80, 17'h1FC84, 17'h1FC88, 17'h1FFF8, 17'h1FFFC};
    expR = 32'h0;
    if (rd && !io) expR = ramRdata;
    else if (rd && reqAddr == 17'h10000) expR = conInValid ? {24'h0, conInByte} : 32'hFFFFFFFF;
    else if (rd && reqAddr == 17'h1FFF4) expR = mCycles / 100;
    if (!reqValid) chk("R11 idle rdata", rdata, 32'h0);
    else if (rd && !io) chk("R1 ram rdata", rdata, expR);
    else if (rd && reqAddr == 17'h10000) chk("R7 console rdata", rdata, expR);
    else if (rd && reqAddr == 17'h1FFF4) chk("R8 timer rdata", rdata, expR);
    else chk("R10 rdata", rdata, expR);
    chk("R1 ramEn", ramEn, reqValid && !io);
    chk("R1 ramWe", ramWe, wr && !io);
    if (reqValid && !io) begin
      chk("R2 ramAddr", ramAddr, algn({15'h0, reqAddr}, reqSize) & 32'hFFFF);
      chk("R1 ramSize", ramSize, reqSize);
      if (wr) chk("R1 ramWdata", ramWdata, reqWdata);
    end
    chk("R5 pmWe", pmWe, wr && reqAddr == 17'h1FC88 && mUnlocked);
    chk("R2 R4 R5 pmAddr", pmAddr, algn(mPmAddr, reqSize));
    if (pmWe) chk("R5 pmWdata", pmWdata, reqWdata);
    chk("R6 conOutValid", conOutValid, wr && reqAddr == 17'h10000);
    if (conOutValid) chk("R6 conOutByte", conOutByte, reqWdata & 32'hFF);
    chk("R7 conInReady", conInReady, rd && reqAddr == 17'h10000);
    chk("R9 dbgValid", dbgValid, wr && reqAddr == 17'h1FFF8);
    if (dbgValid) chk("R9 dbgData", dbgData, reqWdata);
    chk("R9 exitValid", exitValid, wr && reqAddr == 17'h1FFFC);
    if (exitValid) chk("R9 exitData", exitData, exitCode);
    chk("R10 illegalRead", illegalRead, rd && io && reqAddr != 17'h10000 && reqAddr != 17'h1FFF4);
    chk("R10 unknownWrite", unknownWrite, wr && io && !knownW);
  end

  task automatic acc(input bit w, input logic [16:0] a, input logic [1:0] s, input logic [31:0] d);
    reqValid = 1'b1; reqWrite = w; reqAddr = a; reqSize = s; reqWdata = d;
    @(posedge clk); #2;
    reqValid = 1'b0; reqWrite = 1'b0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin @(posedge clk); #2; end
  endtask

  initial begin
    idle(3);
    rst = 1'b0;
    idle(2);                                   // R11 reset outputs
    // R1 / R2 data RAM path
    ramRdata = 32'hCAFE0123;
    acc(0, 17'h01237, 2'd2, 0);
    acc(0, 17'h0FFFF, 2'd1, 0);
    acc(0, 17'h04561, 2'd0, 0);
    acc(1, 17'h0ABCE, 2'd2, 32'h11223344);
    acc(1, 17'h00003, 2'd1, 32'h5566);
    // R5 locked data store is ignored
    acc(1, 17'h1FC84, 2'd2, 32'h00000200);   // R4
    acc(1, 17'h1FC88, 2'd2, 32'hDEAD0001);
    // R3 wrong key, then key
    acc(1, 17'h1FC80, 2'd2, 32'h1337F7D0);
    acc(1, 17'h1FC88, 2'd2, 32'hDEAD0002);
    acc(1, 17'h1FC80, 2'd2, KEY);
    acc(1, 17'h1FC84, 2'd2, 32'h00000102);   // R4
    acc(1, 17'h1FC88, 2'd2, 32'hA0A0A0A0);   // R5
    acc(1, 17'h1FC88, 2'd1, 32'hB1B1B1B1);
    acc(1, 17'h1FC88, 2'd0, 32'hC2C2C2C2);
    acc(1, 17'h1FC80, 2'd2, 32'h0);          // R3 relock
    acc(1, 17'h1FC88, 2'd2, 32'hD3D3D3D3);
    acc(1, 17'h1FC88, 2'd1, 32'hE4E4E4E4);
    acc(0, 17'h1FC80, 2'd2, 0);              // R10 read of key reg
    // R6 / R7 console
    acc(1, 17'h10000, 2'd0, 32'h12345641);
    conInValid = 1'b1; conInByte = 8'h9C;
    acc(0, 17'h10000, 2'd0, 0);
    conInValid = 1'b0;
    acc(0, 17'h10000, 2'd0, 0);
    // R9
    exitCode = 32'h0000002A;
    acc(1, 17'h1FFF8, 2'd2, 32'h87654321);
    acc(1, 17'h1FFFC, 2'd2, 32'h0);
    // R10
    acc(1, 17'h1FC8C, 2'd2, 32'h1);
    acc(1, 17'h10001, 2'd0, 32'h1);
    acc(0, 17'h1FFF0, 2'd2, 0);
    // R8 timer across boundaries
    acc(0, 17'h1FFF4, 2'd2, 0);
    idle(230);
    acc(0, 17'h1FFF4, 2'd2, 0);
    // R11 reset mid-run
    acc(1, 17'h1FC80, 2'd2, KEY);
    rst = 1'b1; idle(2); rst = 1'b0;
    acc(0, 17'h1FFF4, 2'd2, 0);
    acc(1, 17'h1FC88, 2'd2, 32'h77777777);   // locked again after reset
    idle(2);
    if (!finished) begin
      finished = 1;
      $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
      $finish;
    end
  end

  initial begin
    #(PERIOD * 200000);
    if (!finished) begin
      finished = 1;
      nChecks++; nFail++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
      $finish;
    end
  end
endmodule